// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped GPIO peripheral built from a parameterised number of 32-pin register groups. Each group decides per pin whether the pin is an input or an output. It holds an output-data word that software can write directly, or change bit by bit through write-one-to-set and write-one-to-clear words. Pad levels come back through a two-flop synchronizer. Every pin can raise a sticky interrupt status bit on a rising edge, a falling edge, or both.

The status word of each group is split into two 16-pin halves, and each half drives its own interrupt line. A global enable word gates those lines one by one. Software uses a simple single-cycle port: a write takes effect at the clock edge on which it is presented, and read data is combinational from the address while a read is selected.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (direction word reads all ones, `pad_oe` low), output data reads 0 and `pad_out` is 0, all edge enables, status bits and bank enables read 0, and every `bank_irq` line is low.
- R2: The byte address map is as follows. Group k starts at 0x10 + 0x28*k and holds ten words at offsets 0x00 to 0x24 from its start: direction, output data, set-data, clear-data, input data, set-rising, clear-rising, set-falling, clear-falling, interrupt status. The bank-enable word is at 0x08. Any other address reads 0, and a write to one group leaves every other group unchanged.
- R3: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 drives the pin, with `pad_oe` 1 and `pad_out` equal to the output-data bit.
- R4: A write to set-data sets every output-data bit where the written bit is 1. A write to clear-data clears those bits. Written zeros leave bits unchanged. Reading either word returns the output data.
- R5: The input-data word returns the pad level through two synchronizing flops, also for pins driven as outputs. A pad change presented before clock edge E1 reads back after edge E2 and not after E1.
- R6: The rising-edge and falling-edge enables are each a mask changed by write-one-to-set and write-one-to-clear words. Either word of a pair reads back the current mask. An edge direction that is not enabled never sets status.
- R7: An enabled edge of the synchronized pin level sets the pin's status bit three clock edges after the pad change. With both directions enabled, both edges set it.
- R8: Status bits stay set until a 1 is written to them in the status word. Writing 0 has no effect. If a new enabled edge arrives in the same cycle as the clearing write, the bit stays set.
- R9: Interrupt bank 2k follows status bits 15:0 of group k, and bank 2k+1 follows bits 31:16. `bank_irq[n]` is high while bank-enable bit n is 1 and any of its 16 status bits is 1.
- R10: Writes to the input-data word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| pad_in | input | 32*NUM_SETS | Pad levels, asynchronous |
| pad_out | output | 32*NUM_SETS | Output-data value per pin |
| pad_oe | output | 32*NUM_SETS | Drive enable per pin, inverse of direction |
| bank_irq | output | 2*NUM_SETS | Gated interrupt per 16-pin bank |

## Verification
The hardest case to reach is a clearing write to the status word that lands in the same cycle as a fresh enabled edge on the same pin. The bench has to count the synchronizer and edge-detect registers exactly, so it moves the pad and waits two edges before it presents the clear, and the clear then shares its edge with the detection. The second hard part is the split of one status word into two gated banks. The bench uses a pin in the upper half of the second group, so that only bank 3 may rise, and it toggles that bank's enable while status stays set.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and the word-select type for the banked GPIO controller.
// Assumes byte addressing with 32-bit aligned words.
package gpio_bank_pkg;

    localparam int unsigned PINS_PER_SET  = 32;
    localparam int unsigned PINS_PER_BANK = 16;
    localparam int unsigned WORDS_PER_SET = 10;
    localparam int unsigned SET_BASE      = 'h10;
    localparam int unsigned SET_STRIDE    = 'h28;
    localparam int unsigned BANK_EN_ADDR  = 'h08;

    // Word order inside a group; the address decode depends on it.
    typedef enum logic [3:0] {
        W_DIR  = 4'd0,
        W_DOUT = 4'd1,
        W_DSET = 4'd2,
        W_DCLR = 4'd3,
        W_DIN  = 4'd4,
        W_RSET = 4'd5,
        W_RCLR = 4'd6,
        W_FSET = 4'd7,
        W_FCLR = 4'd8,
        W_STAT = 4'd9
    } word_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Capture, then re-register, each pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pin_set.sv
// One 32-pin register group: direction, output data with set/clear words,
// edge enables with set/clear words, edge detection and sticky W1C status.
// Assumes pad_sync is already synchronous to clk and that wr_en is only
// high when the address hits this group.
module gpio_pin_set
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = PINS_PER_SET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  word_e           word,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pad_sync,
    output logic [PINS-1:0] dir_o,
    output logic [PINS-1:0] dout_o,
    output logic [PINS-1:0] status_o,
    output logic [PINS-1:0] rdata_o
);

    logic [PINS-1:0] rise_en;
    logic [PINS-1:0] fall_en;
    logic [PINS-1:0] prev_lvl;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] stat_clr;

    // Enabled edges seen in this cycle, from the synchronized level.
    always_comb begin
        edge_hit = (pad_sync & ~prev_lvl & rise_en) |
                   (~pad_sync & prev_lvl & fall_en);
    end

    // Bits that a write to the status word asks to clear.
    always_comb begin
        stat_clr = (wr_en && word == W_STAT) ? wdata : '0;
    end

    // Configuration registers, level history and status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o    <= '1;
            dout_o   <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            prev_lvl <= '0;
            status_o <= '0;
        end else begin
            prev_lvl <= pad_sync;
            status_o <= (status_o & ~stat_clr) | edge_hit;
            if (wr_en) begin
                case (word)
                    W_DIR:   dir_o   <= wdata;
                    W_DOUT:  dout_o  <= wdata;
                    W_DSET:  dout_o  <= dout_o | wdata;
                    W_DCLR:  dout_o  <= dout_o & ~wdata;
                    W_RSET:  rise_en <= rise_en | wdata;
                    W_RCLR:  rise_en <= rise_en & ~wdata;
                    W_FSET:  fall_en <= fall_en | wdata;
                    W_FCLR:  fall_en <= fall_en & ~wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read mux for the selected word.
    always_comb begin
        case (word)
            W_DIR:                  rdata_o = dir_o;
            W_DOUT, W_DSET, W_DCLR: rdata_o = dout_o;
            W_DIN:                  rdata_o = pad_sync;
            W_RSET, W_RCLR:         rdata_o = rise_en;
            W_FSET, W_FCLR:         rdata_o = fall_en;
            W_STAT:                 rdata_o = status_o;
            default:                rdata_o = '0;
        endcase
    end

    AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == W_DSET) |=> ((dout_o & $past(wdata)) == $past(wdata))); // R4
    AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == W_DCLR) |=> ((dout_o & $past(wdata)) == '0)); // R4
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && word == W_STAT) |=> ((status_o & $past(status_o)) == $past(status_o))); // R8
    AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~$past(status_o) & ~($past(rise_en) | $past(fall_en))) == '0)); // R6

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Top of the banked GPIO controller. Decodes the byte address into the
// bank-enable word and NUM_SETS register groups, synchronizes the pads,
// and gates each 16-pin half of every status word onto its own line.
// Assumes NUM_SETS is at most 5 and ADDR_W covers the last group.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_sel,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_SETS*PINS_PER_SET-1:0] pad_in,
    output logic [NUM_SETS*PINS_PER_SET-1:0] pad_out,
    output logic [NUM_SETS*PINS_PER_SET-1:0] pad_oe,
    output logic [2*NUM_SETS-1:0]         bank_irq
);

    localparam int unsigned PINS_TOTAL = NUM_SETS * PINS_PER_SET;
    localparam int unsigned NUM_BANKS  = 2 * NUM_SETS;
    localparam int unsigned SET_BYTES  = WORDS_PER_SET * 4;

    logic [PINS_TOTAL-1:0]   pad_sync;
    logic [PINS_TOTAL-1:0]   dir_all;
    logic [PINS_TOTAL-1:0]   status_all;
    logic [NUM_BANKS-1:0]    bank_en;
    logic [NUM_SETS-1:0]     set_hit;
    logic [31:0]             set_rd [NUM_SETS];
    logic                    en_hit;
    logic [31:0]             mux_rd;

    gpio_sync #(.WIDTH(PINS_TOTAL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    assign en_hit = (reg_addr == ADDR_W'(BANK_EN_ADDR));

    // Per-bank interrupt enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en <= '0;
        end else if (reg_sel && reg_we && en_hit) begin
            bank_en <= reg_wdata[NUM_BANKS-1:0];
        end
    end

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SET_BASE + k * SET_STRIDE);
        logic [ADDR_W-1:0] rel;
        word_e             word;

        assign rel        = reg_addr - BASE;
        assign set_hit[k] = (reg_addr >= BASE) && (rel < ADDR_W'(SET_BYTES)) &&
                            (reg_addr[1:0] == 2'b00);
        assign word       = word_e'(set_hit[k] ? rel[5:2] : 4'd0);

        gpio_pin_set #(.PINS(PINS_PER_SET)) u_pin_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_sel && reg_we && set_hit[k]),
            .word     (word),
            .wdata    (reg_wdata),
            .pad_sync (pad_sync[k*PINS_PER_SET +: PINS_PER_SET]),
            .dir_o    (dir_all[k*PINS_PER_SET +: PINS_PER_SET]),
            .dout_o   (pad_out[k*PINS_PER_SET +: PINS_PER_SET]),
            .status_o (status_all[k*PINS_PER_SET +: PINS_PER_SET]),
            .rdata_o  (set_rd[k])
        );
    end

    assign pad_oe = ~dir_all;

    // Combine the read data of the hit group and the enable word.
    always_comb begin
        mux_rd = en_hit ? 32'(bank_en) : 32'h0;
        for (int k = 0; k < NUM_SETS; k++) begin
            if (set_hit[k]) begin
                mux_rd = mux_rd | set_rd[k];
            end
        end
        reg_rdata = (reg_sel && !reg_we) ? mux_rd : 32'h0;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned LO = (b / 2) * PINS_PER_SET + (b % 2) * PINS_PER_BANK;
        assign bank_irq[b] = bank_en[b] & (|status_all[LO +: PINS_PER_BANK]);
    end

    AST_ONE_GROUP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_hit)); // R2
    AST_NO_HIT_WITH_ENABLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        en_hit |-> (set_hit == '0)); // R2

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

    localparam int NS = 2;
    localparam int NP = NS * 32;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 direction
        '{1'b0, 8'h14, 32'h0,        32'h00000000, 4'd1},  // R1 output data
        '{1'b0, 8'h34, 32'h0,        32'h00000000, 4'd1},  // R1 status
        '{1'b0, 8'h08, 32'h0,        32'h00000000, 4'd1},  // R1 bank enable
        '{1'b1, 8'h14, 32'hA5A50000, 32'h0,        4'd4},
        '{1'b0, 8'h14, 32'h0,        32'hA5A50000, 4'd4},  // R4 direct write
        '{1'b1, 8'h18, 32'h000000FF, 32'h0,        4'd4},
        '{1'b0, 8'h14, 32'h0,        32'hA5A500FF, 4'd4},  // R4 set word
        '{1'b1, 8'h1C, 32'hA000000F, 32'h0,        4'd4},
        '{1'b0, 8'h14, 32'h0,        32'h05A500F0, 4'd4},  // R4 clear word
        '{1'b0, 8'h1C, 32'h0,        32'h05A500F0, 4'd4},  // R4 clear word reads data
        '{1'b1, 8'h24, 32'h00000011, 32'h0,        4'd6},
        '{1'b1, 8'h24, 32'h00000100, 32'h0,        4'd6},
        '{1'b0, 8'h28, 32'h0,        32'h00000111, 4'd6},  // R6 accumulate
        '{1'b1, 8'h28, 32'h00000001, 32'h0,        4'd6},
        '{1'b0, 8'h24, 32'h0,        32'h00000110, 4'd6},  // R6 clear one
        '{1'b1, 8'h54, 32'hFFFF0000, 32'h0,        4'd6},
        '{1'b0, 8'h58, 32'h0,        32'hFFFF0000, 4'd6},  // R6 falling pair
        '{1'b0, 8'h2C, 32'h0,        32'h00000000, 4'd2},  // R2 group 0 untouched
        '{1'b1, 8'h08, 32'h0000000A, 32'h0,        4'd2},
        '{1'b0, 8'h08, 32'h0,        32'h0000000A, 4'd2},  // R2 enable word
        '{1'b0, 8'h0C, 32'h0,        32'h00000000, 4'd2},  // R2 unmapped
        '{1'b0, 8'h04, 32'h0,        32'h00000000, 4'd2},  // R2 unmapped
        '{1'b1, 8'h3C, 32'h12345678, 32'h0,        4'd2},
        '{1'b0, 8'h3C, 32'h0,        32'h12345678, 4'd2},  // R2 group 1 data
        '{1'b0, 8'h14, 32'h0,        32'h05A500F0, 4'd2},  // R2 isolation
        '{1'b1, 8'h20, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b0, 8'h20, 32'h0,        32'h00000000, 4'd10}, // R10 input word write ignored
        '{1'b0, 8'h60, 32'h0,        32'h00000000, 4'd2},  // R2 past last group
        '{1'b1, 8'h10, 32'h00000000, 32'h0,        4'd3},
        '{1'b0, 8'h10, 32'h0,        32'h00000000, 4'd3}   // R3 all outputs
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [2*NS-1:0] bank_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.NUM_SETS(NS), .ADDR_W(8)) u_gpio_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .bank_irq  (bank_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string req);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        check(req, 64'(reg_rdata), 64'(e));
        reg_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pad_in = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(1);
        do_reset();

        // R1: pins after reset
        check("R1", 64'(pad_oe), 64'h0);
        check("R1", 64'(pad_out), 64'h0);
        check("R1", 64'(bank_irq), 64'h0);

        // Table walk: map, set/clear, enables, ignored writes
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else bus_read(VECS[i].addr, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
        end

        // R3: group 0 fully driven, group 1 still input
        check("R3", 64'(pad_oe), 64'h00000000_FFFFFFFF);
        check("R3", 64'(pad_out[31:0]), 64'h05A500F0);

        // R5: two-flop latency, output pin reads its pad
        do_reset();
        bus_write(8'h10, 32'hFFFFFFFE);
        check("R3", 64'(pad_oe[31:0]), 64'h1);
        pad_in[31:0] = 32'h80000001;
        tick(1);
        bus_read(8'h20, 32'h0, "R5");
        tick(1);
        bus_read(8'h20, 32'h80000001, "R5");

        // R7/R9: rising only on pin 0, bank 0
        do_reset();
        bus_write(8'h24, 32'h1);
        bus_write(8'h08, 32'h1);
        pad_in[0] = 1'b1;
        tick(2);
        bus_read(8'h34, 32'h0, "R7");
        tick(1);
        bus_read(8'h34, 32'h1, "R7");
        check("R9", 64'(bank_irq), 64'h1);
        bus_write(8'h34, 32'h1);
        bus_read(8'h34, 32'h0, "R8");
        check("R9", 64'(bank_irq), 64'h0);
        pad_in[0] = 1'b0;
        tick(3);
        bus_read(8'h34, 32'h0, "R6"); // falling not enabled

        // R7/R8/R9: both edges on group 1 pin 17, bank 3
        do_reset();
        bus_write(8'h4C, 32'h00020000);
        bus_write(8'h54, 32'h00020000);
        bus_write(8'h08, 32'h8);
        pad_in[49] = 1'b1;
        tick(3);
        bus_read(8'h5C, 32'h00020000, "R7");
        check("R9", 64'(bank_irq), 64'h8);
        bus_write(8'h5C, 32'h0);
        bus_read(8'h5C, 32'h00020000, "R8");
        bus_write(8'h5C, 32'h00020000);
        bus_read(8'h5C, 32'h0, "R8");
        check("R9", 64'(bank_irq), 64'h0);
        pad_in[49] = 1'b0;
        tick(3);
        bus_read(8'h5C, 32'h00020000, "R7"); // falling edge
        // R8: new edge coincides with the clearing write
        pad_in[49] = 1'b1;
        tick(2);
        bus_write(8'h5C, 32'h00020000);
        bus_read(8'h5C, 32'h00020000, "R8");
        bus_write(8'h5C, 32'h00020000);
        bus_read(8'h5C, 32'h0, "R8");
        pad_in[49] = 1'b0;
        tick(3);
        check("R9", 64'(bank_irq), 64'h8);
        bus_write(8'h08, 32'h0);
        check("R9", 64'(bank_irq), 64'h0);
        bus_write(8'h08, 32'h4);
        check("R9", 64'(bank_irq), 64'h0);
        bus_write(8'h08, 32'h8);
        check("R9", 64'(bank_irq), 64'h8);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule